// File: doc/BRIEF.md
# Audio FIFO Error and Interrupt Status

This block holds the error and interrupt status for a serial audio port that moves samples through a data FIFO. A mode input picks the direction. In transmit mode the CPU loads samples into the FIFO. In receive mode samples arrive from the serial side into a receive holding register, which the CPU then reads. The block watches the datapath strobes and the FIFO fill level. It keeps a sticky overrun flag and a live idle flag. Each flag has its own interrupt enable.

Software reaches the block through a small register port. One 4-bit word carries the overrun flag, the idle flag and the two enables. Writing zero to the overrun flag clears it. The idle flag cannot be written. Each flag that is enabled drives its own interrupt line, and the two lines are combined by OR into one request. The block also gates transmit writes, so that no write is accepted while the FIFO is full. It keeps the receive holding register, which always holds the newest sample.

Top module: `audio_fifo_status`

## Requirements
- R1: After reset, the overrun flag and both enables read 0, the idle flag reads 1, and all three interrupt outputs are 0. The register word is laid out as bit 0 overrun flag, bit 1 idle flag, bit 2 overrun enable, bit 3 idle enable.
- R2: In receive mode (`mode_tx`=0), the overrun flag is set on the clock edge where `ser_rx` arrives while an earlier sample is still unread and `cpu_rd` is not asserted in that cycle. `cpu_wr` never sets the flag in receive mode.
- R3: Every `ser_rx` loads `ser_data` into `rx_data`, replacing any unread sample. A sample counts as unread from its arrival until a `cpu_rd`.
- R4: In transmit mode (`mode_tx`=1), the overrun flag is set on the clock edge where `cpu_wr` occurs while `fifo_count` equals DEPTH. A write at any lower count does not set it, and `ser_rx` never sets it in transmit mode.
- R5: `tx_accept` is 1 only in transmit mode, in a cycle with `cpu_wr` and with `fifo_count` below DEPTH. A write to a full FIFO is not accepted, so the FIFO is left unchanged.
- R6: The overrun flag is set whatever its enable is. It stays set until a register write with bit 0 equal to 0 clears it. A register write with bit 0 equal to 1 leaves it unchanged.
- R7: If a clearing register write and an overrun event happen in the same cycle, the flag is 1 afterwards.
- R8: The idle flag takes the value of `idle_in` one cycle later, whatever its enable is. Register writes have no effect on it.
- R9: `ovf_irq` equals overrun flag AND overrun enable. `idle_irq` equals idle flag AND idle enable. `irq` is their OR.
- R10: A register write loads both enables from bits 2 and 3, and `reg_rdata` shows them there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tx | input | 1 | 1 transmit, 0 receive |
| reg_wr | input | 1 | Status/enable register write strobe |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data |
| cpu_wr | input | 1 | CPU write to transmit data register |
| cpu_rd | input | 1 | CPU read of receive data register |
| ser_rx | input | 1 | Serial-side sample arrival strobe |
| ser_data | input | DATA_W | Arriving sample |
| rx_data | output | DATA_W | Receive holding register |
| fifo_count | input | CNT_W | FIFO fill level |
| idle_in | input | 1 | Port idle indication |
| tx_accept | output | 1 | Transmit write accepted into FIFO |
| ovf_irq | output | 1 | Overrun interrupt |
| idle_irq | output | 1 | Idle interrupt |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong value in the unread-sample tracker shows up on the next arrival. The overrun bit at bit 0 of `reg_rdata` is then wrong one edge after the `ser_rx` strobe. A fault in the full compare shows at once on `tx_accept`, and one edge later on the overrun bit. A corrupted enable or idle register shows in the same cycle on the interrupt outputs, because they are built from register state with no added delay.

// File: rtl/audio_fifo_status.sv
module audio_fifo_status #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tx,
  input  logic              reg_wr,
  input  logic [3:0]        reg_wdata,
  output logic [3:0]        reg_rdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              ser_rx,
  input  logic [DATA_W-1:0] ser_data,
  output logic [DATA_W-1:0] rx_data,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              idle_in,
  output logic              tx_accept,
  output logic              ovf_irq,
  output logic              idle_irq,
  output logic              irq
);

  logic ovf_q, idle_q, ovf_en_q, idle_en_q, unread_q;
  logic [DATA_W-1:0] rx_q;

  wire full    = (fifo_count == CNT_W'(DEPTH));
  wire ovf_evt = mode_tx ? (cpu_wr & full) : (ser_rx & unread_q & ~cpu_rd);
  wire ovf_clr = reg_wr & ~reg_wdata[0];

  assign tx_accept = mode_tx & cpu_wr & ~full;
  assign reg_rdata = {idle_en_q, ovf_en_q, idle_q, ovf_q};
  assign rx_data   = rx_q;
  assign ovf_irq   = ovf_q & ovf_en_q;
  assign idle_irq  = idle_q & idle_en_q;
  assign irq       = ovf_irq | idle_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q     <= 1'b0;
      idle_q    <= 1'b1;
      ovf_en_q  <= 1'b0;
      idle_en_q <= 1'b0;
      unread_q  <= 1'b0;
      rx_q      <= '0;
    end else begin
      ovf_q  <= ovf_evt | (ovf_q & ~ovf_clr);
      idle_q <= idle_in;
      if (reg_wr) begin
        ovf_en_q  <= reg_wdata[2];
        idle_en_q <= reg_wdata[3];
      end
      if (ser_rx) begin
        rx_q     <= ser_data;
        unread_q <= 1'b1;
      end else if (cpu_rd) begin
        unread_q <= 1'b0;
      end
    end
  end

  assert_rx_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_tx && ser_rx && unread_q && !cpu_rd |=> reg_rdata[0]);
  assert_rx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rx |=> rx_data == $past(ser_data));
  assert_tx_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tx && cpu_wr && fifo_count == CNT_W'(DEPTH) |=> reg_rdata[0]);
  assert_no_accept_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |-> (fifo_count != CNT_W'(DEPTH)) && mode_tx);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && !(reg_wr && !reg_wdata[0]) |=> reg_rdata[0]);
  assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_wdata[0] && mode_tx && cpu_wr && fifo_count == CNT_W'(DEPTH) |=> reg_rdata[0]);
  assert_idle_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> reg_rdata[1] == $past(idle_in));
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[0] && reg_rdata[2]) || (reg_rdata[1] && reg_rdata[3]));

endmodule

// File: tb/test_audio_fifo_status.sv
module test_audio_fifo_status;
  localparam int DEPTH = 8, DATA_W = 16, CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, mode_tx = 0, reg_wr = 0, cpu_wr = 0, cpu_rd = 0, ser_rx = 0, idle_in = 1;
  logic [3:0] reg_wdata = '0;
  logic [DATA_W-1:0] ser_data = '0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic [3:0] reg_rdata;
  logic [DATA_W-1:0] rx_data;
  logic tx_accept, ovf_irq, idle_irq, irq;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_fifo_status #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_audio_fifo_status (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] d);
    reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; #1;
    chk("R1 rdata", reg_rdata, 4'b0010);
    chk("R1 irq", {ovf_irq, idle_irq, irq}, 3'b000);

    // R4/R5: transmit sweep over every fill level
    mode_tx = 1;
    for (int c = 0; c <= DEPTH; c++) begin
      wr(4'b0000);
      fifo_count = CNT_W'(c); cpu_wr = 1; #1;
      chk("R5 accept", tx_accept, (c != DEPTH));
      step(); cpu_wr = 0;
      chk("R4 tx overrun", reg_rdata[0], (c == DEPTH));
    end
    // R4: ser_rx ignored in transmit mode
    wr(4'b0000); fifo_count = '0;
    ser_rx = 1; step(); ser_rx = 1; step(); ser_rx = 0;
    chk("R4 ser_rx in tx", reg_rdata[0], 1'b0);

    // R6: sticky, write-1 keeps, write-0 clears, enable irrelevant
    fifo_count = CNT_W'(DEPTH); cpu_wr = 1; step(); cpu_wr = 0;
    repeat (3) step();
    chk("R6 sticky", reg_rdata[0], 1'b1);
    wr(4'b0001);
    chk("R6 write1 keeps", reg_rdata[0], 1'b1);
    wr(4'b0000);
    chk("R6 write0 clears", reg_rdata[0], 1'b0);
    // R7: clear and event same cycle
    cpu_wr = 1; wr(4'b0000); cpu_wr = 0;
    chk("R7 event wins", reg_rdata[0], 1'b1);
    wr(4'b0000); fifo_count = '0;

    // R5: no accept in receive mode
    mode_tx = 0; cpu_wr = 1; #1;
    chk("R5 rx mode accept", tx_accept, 1'b0);
    fifo_count = CNT_W'(DEPTH); step(); cpu_wr = 0;
    chk("R2 cpu_wr in rx", reg_rdata[0], 1'b0);

    // R2/R3: receive sweep over unread/arrival/read
    for (int p = 0; p < 8; p++) begin
      logic u, s, r;
      {u, s, r} = 3'(p);
      cpu_rd = 1; wr(4'b0000); cpu_rd = 0;
      if (u) begin
        ser_rx = 1; ser_data = 16'h1000 + 16'(p); step(); ser_rx = 0;
      end
      ser_rx = s; cpu_rd = r; ser_data = 16'hA000 + 16'(p); step();
      ser_rx = 0; cpu_rd = 0;
      chk("R2 rx overrun", reg_rdata[0], u & s & ~r);
      if (s) chk("R3 newest sample", rx_data, 16'hA000 + 16'(p));
      else if (u) chk("R3 sample held", rx_data, 16'h1000 + 16'(p));
    end
    wr(4'b0000);

    // R8: idle tracks input, writes ignored
    idle_in = 0; step();
    chk("R8 idle low", reg_rdata[1], 1'b0);
    wr(4'b0010);
    chk("R8 write ignored", reg_rdata[1], 1'b0);
    idle_in = 1; step();
    chk("R8 idle high", reg_rdata[1], 1'b1);
    wr(4'b0000);
    chk("R8 write0 ignored", reg_rdata[1], 1'b1);

    // R9/R10: sweep flags and enables
    for (int p = 0; p < 16; p++) begin
      logic o, i, oe, ie;
      {o, i, oe, ie} = 4'(p);
      wr(4'b0000);
      if (o) begin mode_tx = 1; cpu_wr = 1; step(); cpu_wr = 0; mode_tx = 0; end
      idle_in = i;
      wr({ie, oe, 1'b0, 1'b1});
      chk("R10 enables", reg_rdata[3:2], {ie, oe});
      chk("R9 ovf_irq", ovf_irq, o & oe);
      chk("R9 idle_irq", idle_irq, i & ie);
      chk("R9 irq", irq, (o & oe) | (i & ie));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule